// File: doc/BRIEF.md
# Two-Stage Ratio Tick Synthesizer

The block derives a slow clock-enable tick from its input clock. The divide ratio is the product of two cascaded stages. A power-of-two prescaler divides by 2^(N+1). A linear modulus counter then counts prescaler enables and wraps after M+1 of them. Both N and M sit at fixed bit positions in one 32-bit control word. Software sets and reads that word through a plain write strobe and a readback bus.

Each wrap of the modulus stage produces a one-cycle `tickOut` pulse and flips `squareOut`. Flipping on every pulse gives a roughly square wave at half the pulse rate. A new ratio is held back until the next pulse boundary, so the interval already running always finishes at the old ratio.

Top module: `ratio_tick_synth`

## Requirements
- R1: Consecutive `tickOut` pulses are spaced exactly 2^(N+1) × (M+1) input clock cycles apart.
- R2: M is the control word bits [11:0] and N is bits [15:12].
- R3: With N=0 the prescaler divides by 2, so the smallest ratio is 2 and `tickOut` is never high for two cycles in a row.
- R4: A write changes only bits [15:0]. Bits [31:16] keep their value, which is zero from reset, whatever `wrData` carries there, and they have no effect on the ratio.
- R5: `rdData` returns the control word: bits [15:0] as last written and bits [31:16] as zero.
- R6: A new M or N takes effect at the next `tickOut` boundary. The interval in progress when the write lands completes at the old ratio.
- R7: A synchronous active-high `rst` clears the control word, both counters, `tickOut` and `squareOut`. After release the ratio is 2.
- R8: `squareOut` inverts in exactly the cycles in which `tickOut` is high and holds at all other times.
- R9: The largest modulus, M=4095, gives correct spacing together with a small N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data; only bits [15:0] are stored |
| rdData | output | 32 | Current control word |
| tickOut | output | 1 | One-cycle enable pulse at the synthesized rate |
| squareOut | output | 1 | Inverts on every tick, giving half the tick rate |

## Verification
The embedded assertions check on every cycle that both counters stay inside their active limits. They also check that a tick never lasts more than one cycle, that the square output flips exactly with each tick, that the active ratio changes only at a pulse boundary, and that readback follows the previous write. The assertions cannot see whether the spacing actually equals 2^(N+1)×(M+1) or whether an interval in progress completes at the old ratio. Only the bench's scenarios show those, by measuring pulse intervals for many field pairs, for writes carrying junk upper bits, and across a mid-interval reprogram and a reset.

// File: rtl/synth_pkg.sv
package synth_pkg;
  typedef struct packed {
    logic clearAll;  // synchronous clear of every counter and output flop
    logic loadCfg;   // pulse boundary: take up the pending ratio
  } synthStrobe_t;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int N_W = 4,
  localparam int PRE_W = 2 ** N_W
) (
  input  logic           clk,
  input  logic           clear,
  input  logic [N_W-1:0] preSel,
  output logic           preTick
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] preLimit;

  always_comb begin
    span     = (PRE_W+1)'(1) << ({1'b0, preSel} + (N_W+1)'(1));
    preLimit = PRE_W'(span - (PRE_W+1)'(1));
  end

  assign preTick = (preCnt == preLimit);

  always_ff @(posedge clk) begin
    if (clear)        preCnt <= '0;
    else if (preTick) preCnt <= '0;
    else              preCnt <= preCnt + PRE_W'(1);
  end

  // R1: the prescale count never runs past its active limit
  assert_pre_in_range_R1: assert property (@(posedge clk) disable iff (clear)
    preCnt <= preLimit);
endmodule

// File: rtl/tick_modulus.sv
module tick_modulus #(
  parameter int M_W = 12
) (
  input  logic           clk,
  input  logic           clear,
  input  logic           stepEn,
  input  logic [M_W-1:0] modLimit,
  output logic           wrapNow
);
  logic [M_W-1:0] modCnt;

  assign wrapNow = stepEn && (modCnt == modLimit);

  always_ff @(posedge clk) begin
    if (clear)        modCnt <= '0;
    else if (wrapNow) modCnt <= '0;
    else if (stepEn)  modCnt <= modCnt + M_W'(1);
  end

  // R1: the modulus count stays within 0..M
  assert_mod_in_range_R1: assert property (@(posedge clk) disable iff (clear)
    modCnt <= modLimit);
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import synth_pkg::*;
#(
  parameter int M_W = 12,
  parameter int N_W = 4
) (
  input  logic           clk,
  input  synthStrobe_t   strobe,
  input  logic [M_W-1:0] activeM,
  input  logic [N_W-1:0] activeN,
  output logic           wrapNow,
  output logic           tickOut,
  output logic           squareOut
);
  logic preTick;

  tick_prescale #(.N_W(N_W)) uPre (
    .clk    (clk),
    .clear  (strobe.clearAll),
    .preSel (activeN),
    .preTick(preTick)
  );

  tick_modulus #(.M_W(M_W)) uMod (
    .clk     (clk),
    .clear   (strobe.clearAll),
    .stepEn  (preTick),
    .modLimit(activeM),
    .wrapNow (wrapNow)
  );

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      tickOut   <= 1'b0;
      squareOut <= 1'b0;
    end else begin
      tickOut   <= strobe.loadCfg;
      squareOut <= squareOut ^ strobe.loadCfg;
    end
  end

  // R3: minimum ratio of 2 means a tick never lasts two cycles
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (strobe.clearAll)
    tickOut |=> !tickOut);
  // R8: square output flips with every tick
  assert_square_flip_R8: assert property (@(posedge clk) disable iff (strobe.clearAll)
    tickOut |-> (squareOut != $past(squareOut)));
  // R8: square output holds between ticks
  assert_square_hold_R8: assert property (@(posedge clk) disable iff (strobe.clearAll)
    !tickOut |-> $stable(squareOut));
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import synth_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int M_W   = 12,
  parameter int N_W   = 4,
  localparam int FLD_W = M_W + N_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             wrapNow,
  output logic [REG_W-1:0] rdData,
  output synthStrobe_t     strobe,
  output logic [M_W-1:0]   activeM,
  output logic [N_W-1:0]   activeN
);
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'((64'd1 << FLD_W) - 64'd1);

  logic [REG_W-1:0] ctrlReg;

  always_ff @(posedge clk) begin
    if (rst)       ctrlReg <= '0;
    else if (wrEn) ctrlReg <= (ctrlReg & ~FIELD_MASK) | (wrData & FIELD_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeM <= '0;
      activeN <= '0;
    end else if (wrapNow) begin
      activeM <= ctrlReg[M_W-1:0];
      activeN <= ctrlReg[FLD_W-1:M_W];
    end
  end

  always_comb begin
    strobe.clearAll = rst;
    strobe.loadCfg  = wrapNow;
  end

  assign rdData = ctrlReg;

  // R5: readback shows the fields of the previous write
  assert_rdback_R5: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> rdData[FLD_W-1:0] == $past(wrData[FLD_W-1:0]));
  // R4: bits outside the fields never move
  assert_upper_keep_R4: assert property (@(posedge clk) disable iff (rst)
    $stable(rdData[REG_W-1:FLD_W]));
  // R6: the active ratio changes only at a pulse boundary
  assert_cfg_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !($stable(activeM) && $stable(activeN)) |-> $past(wrapNow));
endmodule

// File: rtl/ratio_tick_synth.sv
module ratio_tick_synth
  import synth_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int M_W   = 12,
  parameter int N_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             tickOut,
  output logic             squareOut
);
  synthStrobe_t   strobe;
  logic [M_W-1:0] activeM;
  logic [N_W-1:0] activeN;
  logic           wrapNow;

  tick_ctrl #(.REG_W(REG_W), .M_W(M_W), .N_W(N_W)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrData (wrData),
    .wrapNow(wrapNow),
    .rdData (rdData),
    .strobe (strobe),
    .activeM(activeM),
    .activeN(activeN)
  );

  tick_datapath #(.M_W(M_W), .N_W(N_W)) uData (
    .clk      (clk),
    .strobe   (strobe),
    .activeM  (activeM),
    .activeN  (activeN),
    .wrapNow  (wrapNow),
    .tickOut  (tickOut),
    .squareOut(squareOut)
  );
endmodule

// File: tb/tb_ratio_tick_synth.sv
module tb_ratio_tick_synth;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tickOut, squareOut;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ratio_tick_synth dut (.*);

  always #5 clk = ~clk;

  // {write word, expected spacing}
  localparam logic [63:0] VEC [10] = '{
    {32'h0000_0000, 32'd2},      // M0 N0
    {32'h0000_0001, 32'd4},      // M1 N0
    {32'h0000_1000, 32'd4},      // M0 N1
    {32'h0000_2004, 32'd40},     // M4 N2
    {32'h0000_300A, 32'd176},    // M10 N3
    {32'hDEAD_2004, 32'd40},     // junk upper bits
    {32'h0000_8000, 32'd512},    // M0 N8
    {32'h0000_5063, 32'd6400},   // M99 N5
    {32'h0000_0FFF, 32'd8192},   // M4095 N0
    {32'hFFFF_1FFF, 32'd16384}   // M4095 N1, junk upper bits
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitPulse();
    @(negedge clk);
    while (!tickOut) @(negedge clk);
  endtask

  task automatic countToPulse(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tickOut);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sp;
    logic sqA;
    repeat (3) @(negedge clk);
    check("R7 reset rdData", int'(rdData), 0);
    check("R7 reset tickOut", int'(tickOut), 0);
    check("R7 reset squareOut", int'(squareOut), 0);
    rst = 1'b0;
    waitPulse();
    countToPulse(sp);
    check("R7 R3 ratio after reset", sp, 2);

    // R1 R2 R4 R5 R9: vector walk
    foreach (VEC[i]) begin
      writeCfg(VEC[i][63:32]);
      check("R5 R4 readback", int'(rdData), int'(VEC[i][63:32] & 32'h0000_FFFF));
      waitPulse();
      sqA = squareOut;
      countToPulse(sp);
      check("R1 R2 R9 spacing", sp, int'(VEC[i][31:0]));
      check("R8 square flips", int'(squareOut), int'(!sqA));
      countToPulse(sp);
      check("R1 spacing repeat", sp, int'(VEC[i][31:0]));
    end

    // R6: reprogram mid-interval, current interval completes at old ratio
    writeCfg(32'h0000_0013);   // M19 N0 -> 40
    waitPulse();
    countToPulse(sp);
    check("R6 setup spacing", sp, 40);
    sp = 0;
    do begin
      @(negedge clk); sp++;
      if (sp == 3) begin wrEn = 1'b1; wrData = 32'h0000_0000; end
      if (sp == 4) begin wrEn = 1'b0; end
    end while (!tickOut);
    check("R6 no runt interval", sp, 40);
    countToPulse(sp);
    check("R6 new ratio at boundary", sp, 2);

    // R7: reset in the middle of operation
    writeCfg(32'h0000_2004);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 mid reset rdData", int'(rdData), 0);
    check("R7 mid reset tickOut", int'(tickOut), 0);
    check("R7 mid reset squareOut", int'(squareOut), 0);
    rst = 1'b0;
    waitPulse();
    countToPulse(sp);
    check("R7 ratio 2 after reset", sp, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule